// File: doc/BRIEF.md
# Interrupt Status Register with Gated Clear

This block collects the event indications of a bus bridge into one 32-bit status word. It also drives a single level interrupt toward the host. Each event arrives as a one-cycle pulse and sets a sticky bit. The bit stays set until software writes a 1 to it. A companion 32-bit enable word decides which pending bits may raise the interrupt. The interrupt output is a registered OR of the pending bits that are enabled.

Three bits record received error messages: correctable, non-fatal and fatal. The details of those messages sit in an external error FIFO. A write-1 clears these bits only while that FIFO reports empty, so software must drain the FIFO before the clear takes effect. The link-loss bit is driven by a falling edge of the link-up level. It can only set after the link has been seen up since reset.

A 3-bit configuration completion code is held as one field. The field takes the new code on each completion event and clears as a unit. Software reads the status word and the enable word at two addresses, which are set by parameters.

Top module: `isr_decode_top`

## Requirements
- R1: After reset, the status word, the enable word and `irq_o` are all 0.
- R2: Writing 1 to an implemented status bit at the status address clears it on the next clock edge. Writing 0 leaves the bit unchanged.
- R3: A write-1 to bit 9 (correctable), bit 10 (non-fatal) or bit 11 (fatal) clears that bit only when `err_fifo_empty` is 1 in the write cycle. When `err_fifo_empty` is 0, the bit stays set.
- R4: If an event pulse and a write-1 clear of the same bit occur in the same cycle, the bit is set after that edge.
- R5: A `cfg_cpl_evt` pulse loads `cfg_cpl_code` into bits 7:5 and replaces any earlier code. A write with a 1 in any of bits 7:5 clears all three bits.
- R6: Bit 0 sets one edge after `link_up` falls from 1 to 0. It never sets while `link_up` has stayed 0 since reset.
- R7: Bits 1, 2, 4, 15:12, 19:18, 22 and 31:28 of the status word always read 0, whatever is written or pulsed.
- R8: The enable word is fully read/write and reads back at the enable address. Any other address reads 0.
- R9: `irq_o` equals the OR of (status AND enable) as it stood one cycle earlier. It rises one edge after the first enabled bit sets, and it falls one edge after the last such bit clears or is disabled.
- R10: Each event sets its own bit: `hot_reset_evt` sets bit 3, `cfg_timeout_evt` bit 8, `intx_evt` bit 16 and `msi_evt` bit 17. `bridge_err_evt` bits [0..6] set status bits 20, 21, 23, 24, 25, 26 and 27 in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| link_up | input | 1 | Link-up level |
| hot_reset_evt | input | 1 | Hot reset detected pulse |
| cfg_cpl_evt | input | 1 | Configuration completion pulse |
| cfg_cpl_code | input | 3 | Completion status code, sampled with `cfg_cpl_evt` |
| cfg_timeout_evt | input | 1 | Configuration access timeout pulse |
| err_cor_evt | input | 1 | Correctable error message pulse |
| err_nonfatal_evt | input | 1 | Non-fatal error message pulse |
| err_fatal_evt | input | 1 | Fatal error message pulse |
| intx_evt | input | 1 | Legacy wire interrupt received pulse |
| msi_evt | input | 1 | Message interrupt received pulse |
| bridge_err_evt | input | 7 | Bridge bus error pulses, mapped per R10 |
| err_fifo_empty | input | 1 | External error FIFO is empty |
| irq_o | output | 1 | Level interrupt output |

## Verification
The bench builds the block with `ADDR_W` = 4, `STS_OFFSET` = 0 and `MSK_OFFSET` = 8, which differs from the default spacing of 4. This shows that address decoding follows the parameters and is not a fixed layout. It also leaves a gap address that must read 0. With a 4-bit address, both the unused addresses and the two register addresses can be driven. The fixed bit layout means every status position, including each reserved one, can be checked with whole-word compares.

// File: rtl/isr_pkg.sv
package isr_pkg;

    localparam int unsigned WORD_W = 32;

    // Status bit positions
    localparam int unsigned B_LINK_DOWN  = 0;
    localparam int unsigned B_HOT_RESET  = 3;
    localparam int unsigned B_CFG_LSB    = 5;
    localparam int unsigned B_CFG_MSB    = 7;
    localparam int unsigned B_CFG_TMO    = 8;
    localparam int unsigned B_ERR_COR    = 9;
    localparam int unsigned B_ERR_NF     = 10;
    localparam int unsigned B_ERR_FATAL  = 11;
    localparam int unsigned B_INTX       = 16;
    localparam int unsigned B_MSI        = 17;
    localparam int unsigned N_BRIDGE_ERR = 7;

    // Implemented bits; everything else is reserved and reads 0
    localparam logic [WORD_W-1:0] IMPL_MASK = 32'h0FB3_0FE9;
    // Bits whose clear is interlocked with the error FIFO
    localparam logic [WORD_W-1:0] GATED_MASK = 32'h0000_0E00;
    localparam logic [WORD_W-1:0] CFG_MASK   = 32'h0000_00E0;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_ENABLE
    } reg_sel_e;

    typedef struct packed {
        logic                    link_down;
        logic                    hot_reset;
        logic                    cfg_timeout;
        logic                    err_cor;
        logic                    err_nonfatal;
        logic                    err_fatal;
        logic                    intx;
        logic                    msi;
        logic [N_BRIDGE_ERR-1:0] bridge_err;
    } isr_evt_t;

    // Status bit driven by bridge error lane k (bit 22 is skipped)
    function automatic int unsigned bridge_bit(input int unsigned k);
        return (k < 2) ? (20 + k) : (21 + k);
    endfunction

    // Spread single-bit events onto their status positions
    function automatic logic [WORD_W-1:0] evt_to_set(input isr_evt_t e);
        logic [WORD_W-1:0] v;
        v = '0;
        v[B_LINK_DOWN] = e.link_down;
        v[B_HOT_RESET] = e.hot_reset;
        v[B_CFG_TMO]   = e.cfg_timeout;
        v[B_ERR_COR]   = e.err_cor;
        v[B_ERR_NF]    = e.err_nonfatal;
        v[B_ERR_FATAL] = e.err_fatal;
        v[B_INTX]      = e.intx;
        v[B_MSI]       = e.msi;
        for (int unsigned k = 0; k < N_BRIDGE_ERR; k++) begin
            v[bridge_bit(k)] = e.bridge_err[k];
        end
        return v;
    endfunction

endpackage

// File: rtl/isr_link_watch.sv
module isr_link_watch (
    input  logic clk,
    input  logic rst,
    input  logic link_up,
    output logic down_pulse
);
    // The history flop resets low, so a drop needs an up-sample after reset first.
    logic up_q;

    always_ff @(posedge clk) begin
        if (rst) up_q <= 1'b0;
        else     up_q <= link_up;
    end

    assign down_pulse = up_q & ~link_up;
endmodule

// File: rtl/isr_sticky_bank.sv
module isr_sticky_bank
    import isr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] set_vec,
    input  logic [WORD_W-1:0] clr_vec,
    input  logic              cfg_load,
    input  logic [2:0]        cfg_code,
    output logic [WORD_W-1:0] sts_q
);
    localparam int unsigned CFG_W = B_CFG_MSB - B_CFG_LSB + 1;

    logic [WORD_W-1:0] sts_d;
    logic [CFG_W-1:0]  cfg_d;

    always_comb begin
        // Set has priority over clear, so an event in a clearing cycle is kept.
        sts_d = (sts_q & ~clr_vec) | set_vec;
        if (cfg_load)
            cfg_d = cfg_code;
        else if (|clr_vec[B_CFG_MSB:B_CFG_LSB])
            cfg_d = '0;
        else
            cfg_d = sts_q[B_CFG_MSB:B_CFG_LSB];
        sts_d[B_CFG_MSB:B_CFG_LSB] = cfg_d;
        sts_d = sts_d & IMPL_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) sts_q <= '0;
        else     sts_q <= sts_d;
    end
endmodule

// File: rtl/isr_irq_gen.sv
module isr_irq_gen
    import isr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] sts,
    input  logic [WORD_W-1:0] enable,
    output logic              irq_o
);
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |(sts & enable);
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/isr_decode_top.sv
module isr_decode_top
    import isr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned STS_OFFSET = 0,
    parameter int unsigned MSK_OFFSET = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reg_wr_en,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [31:0]             reg_wdata,
    output logic [31:0]             reg_rdata,
    input  logic                    link_up,
    input  logic                    hot_reset_evt,
    input  logic                    cfg_cpl_evt,
    input  logic [2:0]              cfg_cpl_code,
    input  logic                    cfg_timeout_evt,
    input  logic                    err_cor_evt,
    input  logic                    err_nonfatal_evt,
    input  logic                    err_fatal_evt,
    input  logic                    intx_evt,
    input  logic                    msi_evt,
    input  logic [N_BRIDGE_ERR-1:0] bridge_err_evt,
    input  logic                    err_fifo_empty,
    output logic                    irq_o
);
    localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFFSET);
    localparam logic [ADDR_W-1:0] MSK_A = ADDR_W'(MSK_OFFSET);

    reg_sel_e          sel;
    isr_evt_t          evt;
    logic              link_drop;
    logic [WORD_W-1:0] set_vec;
    logic [WORD_W-1:0] clr_vec;
    logic [WORD_W-1:0] sts_q;
    logic [WORD_W-1:0] msk_q;

    always_comb begin
        if (reg_addr == STS_A)      sel = SEL_STATUS;
        else if (reg_addr == MSK_A) sel = SEL_ENABLE;
        else                        sel = SEL_NONE;
    end

    isr_link_watch u_link (
        .clk        (clk),
        .rst        (rst),
        .link_up    (link_up),
        .down_pulse (link_drop)
    );

    always_comb begin
        evt.link_down    = link_drop;
        evt.hot_reset    = hot_reset_evt;
        evt.cfg_timeout  = cfg_timeout_evt;
        evt.err_cor      = err_cor_evt;
        evt.err_nonfatal = err_nonfatal_evt;
        evt.err_fatal    = err_fatal_evt;
        evt.intx         = intx_evt;
        evt.msi          = msi_evt;
        evt.bridge_err   = bridge_err_evt;
        set_vec          = evt_to_set(evt);
    end

    always_comb begin
        clr_vec = (reg_wr_en && sel == SEL_STATUS) ? reg_wdata : '0;
        // Error-message bits stay set until the error FIFO is drained
        if (!err_fifo_empty) clr_vec = clr_vec & ~GATED_MASK;
    end

    isr_sticky_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .cfg_load (cfg_cpl_evt),
        .cfg_code (cfg_cpl_code),
        .sts_q    (sts_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                               msk_q <= '0;
        else if (reg_wr_en && sel == SEL_ENABLE) msk_q <= reg_wdata;
    end

    isr_irq_gen u_irq (
        .clk    (clk),
        .rst    (rst),
        .sts    (sts_q),
        .enable (msk_q),
        .irq_o  (irq_o)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS: reg_rdata = sts_q;
            SEL_ENABLE: reg_rdata = msk_q;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/isr_decode_checker.sv
module isr_decode_checker
    import isr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned STS_OFFSET = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              link_up,
    input logic              intx_evt,
    input logic              err_fifo_empty,
    input logic [WORD_W-1:0] sts_q,
    input logic [WORD_W-1:0] msk_q,
    input logic              irq_o
);
    localparam logic [ADDR_W-1:0] STS_A = ADDR_W'(STS_OFFSET);

    logic wr_sts;
    assign wr_sts = reg_wr_en && (reg_addr == STS_A);

    // R3: a blocked clear leaves the fatal bit set
    assert_fatal_held_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_sts && reg_wdata[B_ERR_FATAL] && !err_fifo_empty && sts_q[B_ERR_FATAL])
        |=> sts_q[B_ERR_FATAL]);

    // R2: writing 0 to a set bit keeps it
    assert_zero_write_keeps_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_sts && !reg_wdata[27] && sts_q[27]) |=> sts_q[27]);

    // R4: a new event wins over a same-cycle clear
    assert_set_beats_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_sts && reg_wdata[B_INTX] && intx_evt) |=> sts_q[B_INTX]);

    // R6: link loss only follows an up-then-down sequence
    assert_link_drop_seen_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_q[B_LINK_DOWN]) |-> (!$past(link_up) && $past(link_up, 2)));

    // R7: reserved positions never hold a 1
    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (sts_q & ~IMPL_MASK) == '0);

    // R9: interrupt follows enabled pending bits one cycle later
    assert_irq_lag_R9: assert property (@(posedge clk) disable iff (rst)
        irq_o == $past(|(sts_q & msk_q)));
endmodule

bind isr_decode_top isr_decode_checker #(
    .ADDR_W     (ADDR_W),
    .STS_OFFSET (STS_OFFSET)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .reg_wr_en      (reg_wr_en),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .link_up        (link_up),
    .intx_evt       (intx_evt),
    .err_fifo_empty (err_fifo_empty),
    .sts_q          (sts_q),
    .msk_q          (msk_q),
    .irq_o          (irq_o)
);

// File: tb/sim_isr_decode_top.sv
module sim_isr_decode_top;
    localparam int unsigned AW   = 4;
    localparam logic [3:0]  STS  = 4'h0;
    localparam logic [3:0]  MSK  = 4'h8;
    localparam logic [3:0]  GAP  = 4'h4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        link_up = 1'b0;
    logic        hot_reset_evt = 1'b0, cfg_cpl_evt = 1'b0, cfg_timeout_evt = 1'b0;
    logic [2:0]  cfg_cpl_code = '0;
    logic        err_cor_evt = 1'b0, err_nonfatal_evt = 1'b0, err_fatal_evt = 1'b0;
    logic        intx_evt = 1'b0, msi_evt = 1'b0;
    logic [6:0]  bridge_err_evt = '0;
    logic        err_fifo_empty = 1'b1;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    isr_decode_top #(.ADDR_W(AW), .STS_OFFSET(0), .MSK_OFFSET(8)) u0 (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_up(link_up),
        .hot_reset_evt(hot_reset_evt), .cfg_cpl_evt(cfg_cpl_evt),
        .cfg_cpl_code(cfg_cpl_code), .cfg_timeout_evt(cfg_timeout_evt),
        .err_cor_evt(err_cor_evt), .err_nonfatal_evt(err_nonfatal_evt),
        .err_fatal_evt(err_fatal_evt), .intx_evt(intx_evt), .msi_evt(msi_evt),
        .bridge_err_evt(bridge_err_evt), .err_fifo_empty(err_fifo_empty),
        .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    task automatic clear_all();
        err_fifo_empty = 1'b1;
        wr(STS, 32'hFFFF_FFFF);
    endtask

    function automatic int unsigned lane_pos(input int unsigned k);
        return (k < 2) ? (20 + k) : (21 + k);
    endfunction

    task automatic t_reset();
        rd(STS, rv); chk("R1 status", rv, 32'h0);
        rd(MSK, rv); chk("R1 enable", rv, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] exp;
        @(negedge clk);
        hot_reset_evt = 1; cfg_timeout_evt = 1; intx_evt = 1; msi_evt = 1;
        @(negedge clk);
        hot_reset_evt = 0; cfg_timeout_evt = 0; intx_evt = 0; msi_evt = 0;
        rd(STS, rv); chk("R10 single events", rv, 32'h0003_0108);
        clear_all();
        for (int unsigned k = 0; k < 7; k++) begin
            @(negedge clk); bridge_err_evt = 7'(1 << k);
            @(negedge clk); bridge_err_evt = '0;
            exp = 32'h1 << lane_pos(k);
            rd(STS, rv); chk("R10 bridge lane", rv, exp);
            clear_all();
        end
    endtask

    task automatic t_w1c();
        @(negedge clk); bridge_err_evt = 7'h7F; msi_evt = 1;
        @(negedge clk); bridge_err_evt = '0; msi_evt = 0;
        wr(STS, 32'h0);
        rd(STS, rv); chk("R2 zero write", rv, 32'h0FB2_0000);
        wr(STS, 32'h0800_0000);
        rd(STS, rv); chk("R2 single clear", rv, 32'h07B2_0000);
        clear_all();
        rd(STS, rv); chk("R2 full clear", rv, 32'h0);
    endtask

    task automatic t_err_gate();
        @(negedge clk); err_cor_evt = 1; err_fatal_evt = 1; err_nonfatal_evt = 1;
        @(negedge clk); err_cor_evt = 0; err_fatal_evt = 0; err_nonfatal_evt = 0;
        err_fifo_empty = 0;
        wr(STS, 32'h0000_0E00);
        rd(STS, rv); chk("R3 blocked clear", rv, 32'h0000_0E00);
        err_fifo_empty = 1;
        wr(STS, 32'h0000_0800);
        rd(STS, rv); chk("R3 clear after drain", rv, 32'h0000_0600);
        clear_all();
    endtask

    task automatic t_collision();
        @(negedge clk); intx_evt = 1;
        @(negedge clk); intx_evt = 0;
        @(negedge clk);
        intx_evt = 1; reg_wr_en = 1; reg_addr = STS; reg_wdata = 32'h0001_0000;
        @(negedge clk);
        intx_evt = 0; reg_wr_en = 0; reg_wdata = '0;
        rd(STS, rv); chk("R4 set beats clear", rv, 32'h0001_0000);
        clear_all();
    endtask

    task automatic t_cfg();
        @(negedge clk); cfg_cpl_evt = 1; cfg_cpl_code = 3'd5;
        @(negedge clk); cfg_cpl_evt = 0;
        rd(STS, rv); chk("R5 load code 5", rv, 32'h0000_00A0);
        @(negedge clk); cfg_cpl_evt = 1; cfg_cpl_code = 3'd2;
        @(negedge clk); cfg_cpl_evt = 0;
        rd(STS, rv); chk("R5 replace code 2", rv, 32'h0000_0040);
        @(negedge clk); cfg_cpl_evt = 1; cfg_cpl_code = 3'd7;
        @(negedge clk); cfg_cpl_evt = 0;
        wr(STS, 32'h0000_0020);
        rd(STS, rv); chk("R5 field clears whole", rv, 32'h0);
    endtask

    task automatic t_link();
        link_up = 0;
        repeat (4) @(negedge clk);
        rd(STS, rv); chk("R6 never up", rv, 32'h0);
        link_up = 1;
        repeat (3) @(negedge clk);
        rd(STS, rv); chk("R6 up no flag", rv, 32'h0);
        link_up = 0;
        @(negedge clk);
        rd(STS, rv); chk("R6 drop flagged", rv, 32'h0000_0001);
        clear_all();
        repeat (3) @(negedge clk);
        rd(STS, rv); chk("R6 stays low no reflag", rv, 32'h0);
    endtask

    task automatic t_reserved();
        @(negedge clk);
        hot_reset_evt = 1; cfg_timeout_evt = 1; intx_evt = 1; msi_evt = 1;
        err_cor_evt = 1; err_nonfatal_evt = 1; err_fatal_evt = 1;
        bridge_err_evt = 7'h7F; cfg_cpl_evt = 1; cfg_cpl_code = 3'd7;
        @(negedge clk);
        hot_reset_evt = 0; cfg_timeout_evt = 0; intx_evt = 0; msi_evt = 0;
        err_cor_evt = 0; err_nonfatal_evt = 0; err_fatal_evt = 0;
        bridge_err_evt = '0; cfg_cpl_evt = 0;
        rd(STS, rv); chk("R7 all events reserved clear", rv, 32'h0FB3_0FE8);
        clear_all();
        rd(STS, rv); chk("R7 all-ones write", rv, 32'h0);
    endtask

    task automatic t_mask();
        wr(MSK, 32'hA5C3_0F1E);
        rd(MSK, rv); chk("R8 readback", rv, 32'hA5C3_0F1E);
        rd(GAP, rv); chk("R8 gap reads 0", rv, 32'h0);
        wr(MSK, 32'h0);
        rd(MSK, rv); chk("R8 cleared", rv, 32'h0);
    endtask

    task automatic t_irq();
        wr(MSK, 32'h0001_0000);
        @(negedge clk); msi_evt = 1;
        @(negedge clk); msi_evt = 0;
        @(negedge clk);
        chk("R9 masked bit no irq", {31'b0, irq_o}, 32'h0);
        @(negedge clk); intx_evt = 1;
        @(negedge clk); intx_evt = 0;
        chk("R9 one-cycle lag", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R9 irq high", {31'b0, irq_o}, 32'h1);
        @(negedge clk); reg_wr_en = 1; reg_addr = MSK; reg_wdata = 32'h0;
        @(negedge clk); reg_wr_en = 0;
        chk("R9 still high after disable edge", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        chk("R9 low after disable", {31'b0, irq_o}, 32'h0);
        wr(MSK, 32'h0002_0000);
        @(negedge clk);
        chk("R9 high on msi enable", {31'b0, irq_o}, 32'h1);
        wr(STS, 32'h0002_0000);
        @(negedge clk);
        chk("R9 low after clear", {31'b0, irq_o}, 32'h0);
        wr(MSK, 32'h0);
        clear_all();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_map();
        t_w1c();
        t_err_gate();
        t_collision();
        t_cfg();
        t_link();
        t_reserved();
        t_mask();
        t_irq();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule